// File: doc/BRIEF.md
# Dispatch Stage with Width Carry-Over

This block is the gate between decode and the out-of-order back end. Each cycle it may receive one instruction, given as an index and a micro-op count. It decides in the same cycle whether that instruction can leave. The block has a fixed number of dispatch slots per cycle. An instruction that needs more micro-ops than that width is sent only when every slot of the cycle is free. It takes them all, and the micro-ops left over are charged to the cycles that follow. Until that remainder is paid off, no new instruction may enter.

Before an instruction is sent, four gates are tested in a fixed order: dispatch slots, rename-file space, retire-queue space and scheduler status. The first gate that refuses produces a stall code. When all four accept, the block hands out a retire-queue token from a running ring pointer. It reports the dispatch one cycle later with the instruction index and that token. Operand dependency tracking and the scheduler itself live elsewhere. The block only consumes their status.

Top module: `dispatch_stage`

## Requirements
- R1: While reset is held and just after it, `disp_valid` and `stall_valid` are 0 and `in_ready` is 1. The retire token pointer restarts at 0, so the first dispatch after reset carries token 0.
- R2: When an instruction is accepted in a cycle, on the next cycle `disp_valid` is 1 and `disp_idx` equals the accepted `in_idx`. The block accepts at most one instruction per cycle.
- R3: An instruction whose micro-op count exceeds WIDTH is accepted only when all WIDTH slots of the cycle are free. After it is accepted, the pending remainder becomes the count minus WIDTH.
- R4: At the start of each cycle, up to WIDTH of the pending remainder is consumed, and the free slots are WIDTH minus the amount consumed. `in_ready` is 0 while some remainder is still left after that consumption. An instruction offered while `in_ready` is 0, or one that needs more slots than are free, stalls with code 1 (width).
- R5: The gates are tested in this order: width, rename, retire queue, scheduler. Only the first failing gate's code is reported.
- R6: Any set bit in `rename_busy` stalls the instruction with code 2 (rename).
- R7: The retire-queue need is the micro-op count clamped to RQ_DEPTH and raised to at least 1. If `rq_free` is below that need, the instruction stalls with code 3 (retire).
- R8: `sched_status` is coded as follows, and each refusal maps to its own stall code:

  | `sched_status` | Meaning | Stall code |
  |---|---|---|
  | 0 | ready | none |
  | 1 | queue full | 4 |
  | 2 | load queue full | 5 |
  | 3 | store queue full | 6 |
  | 4 | group restriction | 7 |
  | 5 to 7 | unused, treated as group restriction | 7 |

- R9: `disp_token` is the ring pointer value before the dispatch. The pointer then advances by the retire-queue need modulo RQ_DEPTH, so an instruction with zero micro-ops still uses one entry.
- R10: A stalled instruction changes nothing: no token advance and no pending remainder.
- R11: A cycle without `in_valid` produces neither `disp_valid` nor `stall_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_idx | input | IDX_W | Instruction index |
| in_uops | input | UOP_W | Micro-op count |
| rename_busy | input | NFILES | Per rename file: 1 = no room for the new mappings |
| rq_free | input | $clog2(RQ_DEPTH+1) | Free retire-queue entries |
| sched_status | input | 3 | Scheduler status code (R8) |
| in_ready | output | 1 | No pending remainder is left after this cycle's consumption |
| disp_valid | output | 1 | Registered pulse: an instruction was dispatched |
| disp_idx | output | IDX_W | Index of the dispatched instruction |
| disp_token | output | $clog2(RQ_DEPTH) | Retire-queue token given to it |
| stall_valid | output | 1 | Registered pulse: the offered instruction stalled |
| stall_code | output | 3 | Stall reason code (R4, R6, R7, R8) |

## Verification
The assertions check these rules on every cycle:
- An over-wide acceptance only ever happens with all slots free.
- A non-zero remainder strictly shrinks.
- Nothing is accepted while `in_ready` is low.
- Each acceptance is followed by a dispatch pulse with the same index.
- The token pointer holds still when nothing is accepted.
- Dispatch and stall pulses never coincide.

Some behaviour only the bench's scenarios can show. These are:
- the priority between simultaneous refusals;
- the exact stall code chosen for each scheduler status;
- reuse of the slots left over after a short remainder drains;
- the modulo token sequence, including zero-micro-op instructions;
- the reset of the pointer mid-operation.

// File: rtl/disp_pkg.sv
package disp_pkg;

   typedef enum logic [2:0] {
      SCH_READY  = 3'd0,
      SCH_QFULL  = 3'd1,
      SCH_LDFULL = 3'd2,
      SCH_STFULL = 3'd3,
      SCH_GROUP  = 3'd4
   } sched_stat_e;

   typedef enum logic [2:0] {
      STL_NONE   = 3'd0,
      STL_WIDTH  = 3'd1,
      STL_RENAME = 3'd2,
      STL_RETIRE = 3'd3,
      STL_SCHQ   = 3'd4,
      STL_LDQ    = 3'd5,
      STL_STQ    = 3'd6,
      STL_GROUP  = 3'd7
   } stall_code_e;

endpackage

// File: rtl/disp_slot_tracker.sv
module disp_slot_tracker #(
   parameter int WIDTH = 4,
   parameter int UOP_W = 4,
   localparam int SLOT_W = $clog2(WIDTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [UOP_W-1:0]  uops,
   output logic [SLOT_W-1:0] free_slots,
   output logic              busy,
   output logic              room
);

   localparam logic [UOP_W-1:0] W_U = UOP_W'(WIDTH);

   logic [UOP_W-1:0] carry_q, carry_d, drain, left;
   logic             wide;

   if (WIDTH < 1) begin : g_bad_width
      $error("disp_slot_tracker: WIDTH must be at least 1");
   end
   if (WIDTH >= (1 << UOP_W)) begin : g_bad_uopw
      $error("disp_slot_tracker: UOP_W too narrow for WIDTH");
   end

   always_comb begin
      drain      = (carry_q > W_U) ? W_U : carry_q;
      left       = carry_q - drain;
      busy       = (left != '0);
      free_slots = SLOT_W'(WIDTH) - SLOT_W'(drain);
      wide       = (uops > W_U);
      if (wide) room = (32'(free_slots) == WIDTH);
      else      room = (32'(uops) <= 32'(free_slots));
      if (take && wide) carry_d = uops - W_U;
      else              carry_d = left;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) carry_q <= '0;
      else        carry_q <= carry_d;
   end

   // R3
   overwide_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wide) |-> (32'(free_slots) == WIDTH));

   // R4
   carry_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_q != '0) |=> (carry_q < $past(carry_q)));

   // R4
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !take);

endmodule

// File: rtl/disp_check_chain.sv
module disp_check_chain
   import disp_pkg::*;
#(
   parameter int NFILES   = 2,
   parameter int RQ_DEPTH = 16,
   parameter int UOP_W    = 4,
   localparam int NORM_W  = $clog2(RQ_DEPTH + 1)
) (
   input  logic              valid,
   input  logic              busy,
   input  logic              room,
   input  logic [NFILES-1:0] rename_busy,
   input  logic [NORM_W-1:0] rq_free,
   input  logic [2:0]        sched_status,
   input  logic [UOP_W-1:0]  uops,
   output logic              fire,
   output logic              stall,
   output stall_code_e       code,
   output logic [NORM_W-1:0] norm
);

   logic [NORM_W-1:0] clamp;
   sched_stat_e       sst;

   if (NFILES < 1) begin : g_bad_files
      $error("disp_check_chain: NFILES must be at least 1");
   end

   always_comb begin
      clamp = (32'(uops) > RQ_DEPTH) ? NORM_W'(RQ_DEPTH) : NORM_W'(uops);
      norm  = (clamp == '0) ? NORM_W'(1) : clamp;
      sst   = sched_stat_e'(sched_status);
      code  = STL_NONE;
      if (busy || !room)            code = STL_WIDTH;
      else if (|rename_busy)        code = STL_RENAME;
      else if (rq_free < norm)      code = STL_RETIRE;
      else begin
         case (sst)
            SCH_READY:  code = STL_NONE;
            SCH_QFULL:  code = STL_SCHQ;
            SCH_LDFULL: code = STL_LDQ;
            SCH_STFULL: code = STL_STQ;
            default:    code = STL_GROUP;
         endcase
      end
      fire  = valid && (code == STL_NONE);
      stall = valid && (code != STL_NONE);
   end

endmodule

// File: rtl/disp_token_alloc.sv
module disp_token_alloc #(
   parameter int RQ_DEPTH = 16,
   localparam int TOK_W  = $clog2(RQ_DEPTH),
   localparam int NORM_W = $clog2(RQ_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [NORM_W-1:0] norm,
   output logic [TOK_W-1:0]  token
);

   localparam int SUM_W = TOK_W + 2;

   logic [TOK_W-1:0] tail_q, tail_d;

   if (RQ_DEPTH < 2) begin : g_bad_depth
      $error("disp_token_alloc: RQ_DEPTH must be at least 2");
   end

   if ((RQ_DEPTH & (RQ_DEPTH - 1)) == 0) begin : g_pow2
      logic [SUM_W-1:0] sum;
      always_comb begin
         sum    = SUM_W'(tail_q) + SUM_W'(norm);
         tail_d = sum[TOK_W-1:0];
      end
   end else begin : g_wrap
      logic [SUM_W-1:0] sum;
      always_comb begin
         sum = SUM_W'(tail_q) + SUM_W'(norm);
         if (sum >= SUM_W'(RQ_DEPTH)) sum = sum - SUM_W'(RQ_DEPTH);
         tail_d = sum[TOK_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tail_q <= '0;
      else if (take) tail_q <= tail_d;
   end

   assign token = tail_q;

   // R10
   tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(tail_q));

endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
   import disp_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int UOP_W    = 4,
   parameter int IDX_W    = 8,
   parameter int NFILES   = 2,
   parameter int RQ_DEPTH = 16,
   localparam int FREE_W  = $clog2(RQ_DEPTH + 1),
   localparam int TOK_W   = $clog2(RQ_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [UOP_W-1:0]  in_uops,
   input  logic [NFILES-1:0] rename_busy,
   input  logic [FREE_W-1:0] rq_free,
   input  logic [2:0]        sched_status,
   output logic              in_ready,
   output logic              disp_valid,
   output logic [IDX_W-1:0]  disp_idx,
   output logic [TOK_W-1:0]  disp_token,
   output logic              stall_valid,
   output logic [2:0]        stall_code
);

   localparam int SLOT_W = $clog2(WIDTH + 1);

   logic              fire, stall, busy, room;
   logic [SLOT_W-1:0] free_slots;
   logic [FREE_W-1:0] norm;
   logic [TOK_W-1:0]  token;
   stall_code_e       code;

   if (IDX_W < 1) begin : g_bad_idx
      $error("dispatch_stage: IDX_W must be at least 1");
   end

   disp_slot_tracker #(.WIDTH(WIDTH), .UOP_W(UOP_W)) u_slots (
      .clk(clk), .rst_n(rst_n), .take(fire), .uops(in_uops),
      .free_slots(free_slots), .busy(busy), .room(room)
   );

   disp_check_chain #(.NFILES(NFILES), .RQ_DEPTH(RQ_DEPTH), .UOP_W(UOP_W)) u_chain (
      .valid(in_valid), .busy(busy), .room(room), .rename_busy(rename_busy),
      .rq_free(rq_free), .sched_status(sched_status), .uops(in_uops),
      .fire(fire), .stall(stall), .code(code), .norm(norm)
   );

   disp_token_alloc #(.RQ_DEPTH(RQ_DEPTH)) u_tok (
      .clk(clk), .rst_n(rst_n), .take(fire), .norm(norm), .token(token)
   );

   assign in_ready = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_valid  <= 1'b0;
         disp_idx    <= '0;
         disp_token  <= '0;
         stall_valid <= 1'b0;
         stall_code  <= 3'd0;
      end else begin
         disp_valid  <= fire;
         stall_valid <= stall;
         stall_code  <= stall ? 3'(code) : 3'd0;
         if (fire) begin
            disp_idx   <= in_idx;
            disp_token <= token;
         end
      end
   end

   // R2
   disp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (disp_valid && disp_idx == $past(in_idx)));

   // R5
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({disp_valid, stall_valid}));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!disp_valid && !stall_valid));

endmodule

// File: tb/tb_dispatch_stage.sv
`timescale 1ns/1ps
module tb_dispatch_stage;

   localparam int WIDTH = 4, UOP_W = 4, IDX_W = 8, NFILES = 2, RQ_DEPTH = 16;
   localparam int FREE_W = $clog2(RQ_DEPTH + 1), TOK_W = $clog2(RQ_DEPTH);

   typedef struct packed {
      logic       vld;
      logic [3:0] uops;
      logic [1:0] mask;
      logic [4:0] rqf;
      logic [2:0] sch;
      logic [2:0] code;
      logic       rdy;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      {1'b1, 4'd2,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 0  R2
      {1'b1, 4'd0,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 1  R9 zero uops
      {1'b1, 4'd6,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 2  R3 over-wide, remainder 2
      {1'b1, 4'd3,  2'b00, 5'd16, 3'd0, 3'd1, 1'b1},  // 3  R4 only 2 slots free
      {1'b1, 4'd1,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 4
      {1'b1, 4'd2,  2'b01, 5'd16, 3'd0, 3'd2, 1'b1},  // 5  R6
      {1'b1, 4'd2,  2'b10, 5'd0,  3'd2, 3'd2, 1'b1},  // 6  R5 rename wins
      {1'b1, 4'd2,  2'b00, 5'd1,  3'd3, 3'd3, 1'b1},  // 7  R5 retire wins over sched
      {1'b1, 4'd0,  2'b00, 5'd1,  3'd0, 3'd0, 1'b1},  // 8  R7 need of 1 fits
      {1'b1, 4'd3,  2'b00, 5'd16, 3'd1, 3'd4, 1'b1},  // 9  R8
      {1'b1, 4'd3,  2'b00, 5'd16, 3'd2, 3'd5, 1'b1},  // 10 R8
      {1'b1, 4'd3,  2'b00, 5'd16, 3'd3, 3'd6, 1'b1},  // 11 R8
      {1'b1, 4'd3,  2'b00, 5'd16, 3'd4, 3'd7, 1'b1},  // 12 R8
      {1'b1, 4'd12, 2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 13 R3 remainder 8
      {1'b1, 4'd1,  2'b00, 5'd16, 3'd0, 3'd1, 1'b0},  // 14 R4 not ready
      {1'b1, 4'd1,  2'b00, 5'd16, 3'd0, 3'd1, 1'b1},  // 15 R4 ready but 0 free
      {1'b1, 4'd4,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 16
      {1'b1, 4'd9,  2'b00, 5'd8,  3'd0, 3'd3, 1'b1},  // 17 R7
      {1'b1, 4'd5,  2'b00, 5'd16, 3'd4, 3'd7, 1'b1},  // 18 R8
      {1'b1, 4'd5,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 19 R3 remainder 1, token wraps
      {1'b1, 4'd3,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 20 R4 3 slots left after drain
      {1'b1, 4'd4,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1},  // 21
      {1'b0, 4'd2,  2'b00, 5'd16, 3'd0, 3'd0, 1'b1}   // 22 R11
   };

   logic              clk = 1'b0, rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [IDX_W-1:0]  in_idx = '0;
   logic [UOP_W-1:0]  in_uops = '0;
   logic [NFILES-1:0] rename_busy = '0;
   logic [FREE_W-1:0] rq_free = '0;
   logic [2:0]        sched_status = '0;
   logic              in_ready, disp_valid, stall_valid;
   logic [IDX_W-1:0]  disp_idx;
   logic [TOK_W-1:0]  disp_token;
   logic [2:0]        stall_code;

   int checks = 0, errors = 0, tok = 0;

   always #2 clk = ~clk;

   dispatch_stage #(.WIDTH(WIDTH), .UOP_W(UOP_W), .IDX_W(IDX_W), .NFILES(NFILES),
                    .RQ_DEPTH(RQ_DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx), .in_uops(in_uops),
      .rename_busy(rename_busy), .rq_free(rq_free), .sched_status(sched_status),
      .in_ready(in_ready), .disp_valid(disp_valid), .disp_idx(disp_idx),
      .disp_token(disp_token), .stall_valid(stall_valid), .stall_code(stall_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic string tag(input logic [2:0] c);
      case (c)
         3'd0:    return "R2";
         3'd1:    return "R4";
         3'd2:    return "R6";
         3'd3:    return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic int need(input int u);
      int n = (u > RQ_DEPTH) ? RQ_DEPTH : u;
      return (n < 1) ? 1 : n;
   endfunction

   task automatic drive(input logic v, input int idx, input int u, input logic [1:0] m,
                        input int rqf, input int s);
      in_valid = v; in_idx = IDX_W'(idx); in_uops = UOP_W'(u);
      rename_busy = m; rq_free = FREE_W'(rqf); sched_status = 3'(s);
   endtask

   // expects a dispatch of instruction idx with the modelled token (R2, R9)
   task automatic expect_disp(input int idx, input int u, input string req);
      chk(disp_valid === 1'b1 && stall_valid === 1'b0, req, int'(disp_valid), 1);
      chk(disp_idx === IDX_W'(idx), req, int'(disp_idx), idx);
      chk(disp_token === TOK_W'(tok), {req, " R9"}, int'(disp_token), tok);
      tok = (tok + need(u)) % RQ_DEPTH;
   endtask

   initial begin
      #8000;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(disp_valid === 1'b0 && stall_valid === 1'b0, "R1", int'(disp_valid), 0);
      chk(in_ready === 1'b1, "R1", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].vld, i, int'(VEC[i].uops), VEC[i].mask, int'(VEC[i].rqf),
               int'(VEC[i].sch));
         #1;
         chk(in_ready === VEC[i].rdy, "R4", int'(in_ready), int'(VEC[i].rdy));
         @(posedge clk);
         #1;
         if (!VEC[i].vld) begin
            // R11
            chk(disp_valid === 1'b0 && stall_valid === 1'b0, "R11",
                int'({disp_valid, stall_valid}), 0);
         end else if (VEC[i].code == 3'd0) begin
            expect_disp(i, int'(VEC[i].uops), tag(VEC[i].code));
         end else begin
            // R5 / R10: stall leaves token model untouched
            chk(stall_valid === 1'b1 && disp_valid === 1'b0, tag(VEC[i].code),
                int'(stall_valid), 1);
            chk(stall_code === VEC[i].code, tag(VEC[i].code), int'(stall_code),
                int'(VEC[i].code));
         end
         @(negedge clk);
      end

      // R3 over-wide then not ready; R1 asynchronous reset mid-remainder
      drive(1'b1, 40, 12, 2'b00, 16, 0);
      @(posedge clk); #1;
      expect_disp(40, 12, "R3");
      @(negedge clk);
      drive(1'b0, 0, 0, 2'b00, 16, 0);
      #1;
      chk(in_ready === 1'b0, "R4", int'(in_ready), 0);
      rst_n = 1'b0;
      #1;
      chk(in_ready === 1'b1, "R1", int'(in_ready), 1);
      chk(disp_valid === 1'b0 && stall_valid === 1'b0, "R1", int'(disp_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      tok = 0;
      @(negedge clk);
      drive(1'b1, 41, 1, 2'b00, 16, 0);
      @(posedge clk); #1;
      expect_disp(41, 1, "R1");
      @(negedge clk);
      drive(1'b0, 0, 0, 2'b00, 16, 0);
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule